// File: doc/BRIEF.md
# Pin-Selected Power-of-Two Clock Divider

This block derives an output clock from a reference clock by a ratio of 1, 2, 4, 8, 16 or 32. Two select inputs pick the ratio. One reads three levels (low, high or unconnected), and each level arrives as a two-bit code. The other is a plain binary bank select. Together they address two banks of three ratios.

The output leaves as a data bit plus a separate drive-enable flag, ready for a tri-state pad. Two enable inputs gate the output, one active-low and one active-high. Each enable uses the same three-level code as the ratio select, and an unconnected enable counts as asserted. While the output is disabled, the data bit is held HIGH. After the output is enabled again, and after any change of ratio, the divided clock starts over with a complete HIGH phase.

Top module: `pow2_clk_div`

## Requirements
- R1: Three-level codes are 00 = low, 01 = high, 10 or 11 = unconnected. With `bank_i` = 0, the ratio select gives divide-by-1 when unconnected, divide-by-2 when high and divide-by-4 when low.
- R2: With `bank_i` = 1, the ratio select gives divide-by-8 when unconnected, divide-by-16 when high and divide-by-32 when low.
- R3: For a ratio N of 2 or more, `clk_o` holds each level for exactly N/2 reference cycles, and it changes only on rising edges of `clk_i`.
- R4: For divide-by-1, `clk_o` follows `clk_i` while the output is enabled.
- R5: The output is enabled only when `en_lo_i` reads low or unconnected and `en_hi_i` reads high or unconnected. This holds for every select setting.
- R6: `clk_oe_o` is the enable condition registered on the first rising edge of `clk_i` after the enable inputs change.
- R7: While `clk_oe_o` is 0, `clk_o` is 1.
- R8: On the edge where `clk_oe_o` rises, `clk_o` begins a HIGH phase that lasts a full N/2 cycles.
- R9: On the first edge after the decoded ratio changes, `clk_o` restarts HIGH and holds that level for N/2 cycles of the new ratio.
- R10: While `rst_ni` is low, `clk_oe_o` is 0 and `clk_o` is 1.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rsel_i | input | 2 | Three-level ratio select code |
| bank_i | input | 1 | Ratio bank select |
| en_lo_i | input | 2 | Three-level code of the active-low enable |
| en_hi_i | input | 2 | Three-level code of the active-high enable |
| clk_o | output | 1 | Divided clock data |
| clk_oe_o | output | 1 | Pad drive enable for `clk_o` |

## Verification
The bench first disables the block, then walks every select code through it, including the spare code 11. A decoder that ignored that code, or swapped the two banks, would produce the wrong number of cycles in each half period. The bench changes the ratio in the middle of a LOW phase. A divider that kept counting would either hold LOW too long or emit a HIGH pulse that is too short. It also disables the block during a LOW phase and re-enables it through unconnected enable codes. A design that froze the output level, or that read an unconnected enable as inactive, would either leave the output LOW or never enable it.

// File: rtl/pow2_div_pkg.sv
package pow2_div_pkg;
  typedef enum logic [1:0] {
    LVL_LOW   = 2'b00,
    LVL_HIGH  = 2'b01,
    LVL_FLOAT = 2'b10
  } lvl_e;

  // log2 of the divide ratio
  function automatic logic [2:0] ratio_log(input logic [1:0] sel, input logic bank);
    logic [2:0] idx;
    case (sel)
      LVL_LOW:  idx = 3'd2;
      LVL_HIGH: idx = 3'd1;
      default:  idx = 3'd0;
    endcase
    return bank ? idx + 3'd3 : idx;
  endfunction

  // unconnected counts as asserted for both polarities
  function automatic logic en_ok(input logic [1:0] lo_code, input logic [1:0] hi_code);
    return (lo_code != LVL_HIGH) && (hi_code != LVL_LOW);
  endfunction
endpackage

// File: rtl/pow2_div_sel.sv
module pow2_div_sel
  import pow2_div_pkg::*;
#(
  parameter int LOG_W = 3
) (
  input  logic [1:0]       rsel_i,
  input  logic             bank_i,
  output logic [LOG_W-1:0] ratio_log_o
);
  always_comb ratio_log_o = LOG_W'(ratio_log(rsel_i, bank_i));
endmodule

// File: rtl/pow2_div_en.sv
module pow2_div_en
  import pow2_div_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] en_lo_i,
  input  logic [1:0] en_hi_i,
  output logic       en_d_o,
  output logic       en_q_o
);
  assign en_d_o = en_ok(en_lo_i, en_hi_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q_o <= 1'b0;
    else         en_q_o <= en_d_o;
  end
endmodule

// File: rtl/pow2_div_core.sv
module pow2_div_core #(
  parameter int LOG_W = 3,
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [LOG_W-1:0] ratio_i,
  output logic             div_o,
  output logic [LOG_W-1:0] ratio_q_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] half_m1;
  logic             restart;

  always_comb begin
    if (ratio_i == '0) half_m1 = '0;
    else               half_m1 = CNT_W'((32'd1 << (ratio_i - LOG_W'(1))) - 32'd1);
  end

  assign restart = !run_i || (ratio_i != ratio_q_o) || (ratio_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_q_o <= '0;
      cnt_o     <= '0;
      div_o     <= 1'b1;
    end else begin
      ratio_q_o <= ratio_i;
      if (restart) begin
        cnt_o <= '0;
        div_o <= 1'b1;
      end else if (cnt_o == half_m1) begin
        cnt_o <= '0;
        div_o <= ~div_o;
      end else begin
        cnt_o <= cnt_o + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/pow2_clk_div.sv
module pow2_clk_div #(
  parameter int MAX_LOG = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] rsel_i,
  input  logic       bank_i,
  input  logic [1:0] en_lo_i,
  input  logic [1:0] en_hi_i,
  output logic       clk_o,
  output logic       clk_oe_o
);
  localparam int LOG_W = $clog2(MAX_LOG + 1);
  localparam int CNT_W = (MAX_LOG > 1) ? MAX_LOG - 1 : 1;

  logic [LOG_W-1:0] ratio_log;
  logic [LOG_W-1:0] ratio_q;
  logic [CNT_W-1:0] cnt_q;
  logic             en_d, en_q, div_q;

  pow2_div_sel #(.LOG_W(LOG_W)) u_sel (
    .rsel_i     (rsel_i),
    .bank_i     (bank_i),
    .ratio_log_o(ratio_log)
  );

  pow2_div_en u_en (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_lo_i(en_lo_i),
    .en_hi_i(en_hi_i),
    .en_d_o (en_d),
    .en_q_o (en_q)
  );

  // counter runs only once the enable has been registered
  pow2_div_core #(.LOG_W(LOG_W), .CNT_W(CNT_W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (en_d && en_q),
    .ratio_i  (ratio_log),
    .div_o    (div_q),
    .ratio_q_o(ratio_q),
    .cnt_o    (cnt_q)
  );

  assign clk_oe_o = en_q;
  assign clk_o    = !en_q ? 1'b1 : ((ratio_log == '0) ? clk_i : div_q);
endmodule

// File: rtl/pow2_clk_div_chk.sv
module pow2_clk_div_chk
  import pow2_div_pkg::*;
#(
  parameter int LOG_W = 3,
  parameter int CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       en_lo_i,
  input logic [1:0]       en_hi_i,
  input logic             clk_o,
  input logic             clk_oe_o,
  input logic [LOG_W-1:0] ratio_log,
  input logic [LOG_W-1:0] ratio_q,
  input logic [CNT_W-1:0] cnt_q
);
  logic past_ok;
  logic en_c;
  assign en_c = en_ok(en_lo_i, en_hi_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  AST_DISABLED_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_oe_o |-> clk_o); // R7
  AST_OE_REGISTERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> clk_oe_o == $past(en_c)); // R6
  AST_REENABLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $rose(clk_oe_o) && ratio_log != '0) |-> clk_o); // R8
  AST_RATIO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && ratio_q != $past(ratio_q) && clk_oe_o && ratio_log != '0) |-> clk_o); // R9
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio_q != '0) |-> (32'(cnt_q) < (32'd1 << (ratio_q - LOG_W'(1))))); // R3
endmodule

bind pow2_clk_div pow2_clk_div_chk #(.LOG_W(LOG_W), .CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_lo_i  (en_lo_i),
  .en_hi_i  (en_hi_i),
  .clk_o    (clk_o),
  .clk_oe_o (clk_oe_o),
  .ratio_log(ratio_log),
  .ratio_q  (ratio_q),
  .cnt_q    (cnt_q)
);

// File: tb/pow2_clk_div_test.sv
module pow2_clk_div_test;
  localparam int P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] rsel = 2'b10;
  logic       bank = 1'b0;
  logic [1:0] en_lo = 2'b01;
  logic [1:0] en_hi = 2'b01;
  logic       clk_o, clk_oe;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done = 0;

  always #(P/2) clk = ~clk;

  pow2_clk_div uut (
    .clk_i(clk), .rst_ni(rst_n), .rsel_i(rsel), .bank_i(bank),
    .en_lo_i(en_lo), .en_hi_i(en_hi), .clk_o(clk_o), .clk_oe_o(clk_oe)
  );

  // {rsel, bank, log2 ratio}
  localparam logic [5:0] VEC [7] = '{
    {2'b10, 1'b0, 3'd0}, // R1
    {2'b01, 1'b0, 3'd1}, // R1
    {2'b00, 1'b0, 3'd2}, // R1
    {2'b11, 1'b1, 3'd3}, // R2
    {2'b01, 1'b1, 3'd4}, // R2
    {2'b00, 1'b1, 3'd5}, // R2
    {2'b11, 1'b0, 3'd0}  // R1
  };

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // samples taken P/4 after each rising edge; sample 0 follows the restart edge
  task automatic pattern(int half, int n, int start, string req);
    for (int i = start; i < start + n; i++) begin
      @(posedge clk); #(P/4);
      chk(req, clk_o, ((i / half) % 2) == 0);
      chk(req, clk_oe, 1'b1);
    end
  endtask

  task automatic fresh(logic [1:0] s, logic b);
    @(negedge clk); en_lo = 2'b01;
    @(negedge clk); en_lo = 2'b00; en_hi = 2'b01; rsel = s; bank = b;
  endtask

  initial begin
    #(P*100000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    en_lo = 2'b00;
    repeat (3) @(posedge clk);
    #(P/4);
    chk("R10 oe", clk_oe, 1'b0);
    chk("R10 data", clk_o, 1'b1);
    @(negedge clk); rst_n = 1'b1;

    foreach (VEC[k]) begin
      fresh(VEC[k][5:4], VEC[k][3]);
      if (VEC[k][2:0] == 3'd0) begin
        @(posedge clk); #(P/4); chk("R4 oe", clk_oe, 1'b1);
        for (int j = 0; j < 4; j++) begin
          @(posedge clk); #(P/4); chk("R4 high", clk_o, 1'b1);
          @(negedge clk); #(P/4); chk("R4 low", clk_o, 1'b0);
        end
      end else begin
        pattern(1 << (VEC[k][2:0] - 1), 4 << VEC[k][2:0], 0,
                VEC[k][3] ? "R2 R3 R8" : "R1 R3 R8");
      end
    end

    // ratio change in a low phase: div8 then div4
    fresh(2'b10, 1'b1);
    pattern(4, 6, 0, "R3");
    @(negedge clk); rsel = 2'b00; bank = 1'b0;
    pattern(2, 8, 0, "R9");

    // disable during a low phase with active-low enable high
    fresh(2'b00, 1'b1);
    pattern(16, 20, 0, "R3");
    @(negedge clk); en_lo = 2'b01;
    #(P/4); chk("R6 not yet", clk_oe, 1'b1);
    @(posedge clk); #(P/4);
    chk("R6 oe off", clk_oe, 1'b0);
    chk("R7 forced high", clk_o, 1'b1);
    for (int j = 0; j < 5; j++) begin
      @(posedge clk); #(P/4); chk("R7 held", clk_o, 1'b1);
      @(negedge clk); #(P/4); chk("R7 held", clk_o, 1'b1);
    end

    // active-high enable low disables even with active-low enable low
    @(negedge clk); en_lo = 2'b00; en_hi = 2'b00;
    repeat (3) begin
      @(posedge clk); #(P/4);
      chk("R5 hi low", clk_oe, 1'b0);
      chk("R7", clk_o, 1'b1);
    end

    // both enables unconnected enables, restart high
    @(negedge clk); en_lo = 2'b10; en_hi = 2'b11; rsel = 2'b01; bank = 1'b0;
    pattern(1, 6, 0, "R5 R8");

    // disable in divide-by-1 holds data high
    @(negedge clk); rsel = 2'b10; en_hi = 2'b00;
    @(posedge clk); #(P/4); chk("R7 div1", clk_o, 1'b1);
    @(negedge clk); #(P/4); chk("R7 div1", clk_o, 1'b1);

    // async reset mid-run
    fresh(2'b01, 1'b1);
    pattern(8, 10, 0, "R2");
    #(P/8); rst_n = 1'b0; #(P/8);
    chk("R10 oe", clk_oe, 1'b0);
    chk("R10 data", clk_o, 1'b1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule